// File: doc/BRIEF.md
# Serial Clock Synthesizer Loader

This block programs an external frequency synthesizer through a two-wire serial link that has one clock wire and one data wire. A one-cycle start request captures four divider fields: a 4-bit index, a 7-bit N, a 3-bit P and a 7-bit D. The block packs them into a 24-bit control word that always targets the synthesizer's internal register 2. A small sequencer then walks through a fixed series of wire states. The series opens with an unlock preamble and a start bit. The 24 data bits follow in a complement-then-true encoding, and a stop pattern closes it. The whole series is sent three times.

A phase timer holds every wire state for a programmable number of system clocks, so the link speed can be matched to the synthesizer. When the third pass ends, the block sets its 4-bit clock-select output to 2, drops busy and pulses done. Start requests that arrive while a load is running are ignored.

Top module: `serclk_prog`

## Requirements
- R1: After reset, both link wires are low, the clock-select output is 0, and busy and done are low.
- R2: The transmitted word has bits 23:21 = 3'b010, bits 20:17 = index, bits 16:10 = N, bits 9:7 = P and bits 6:0 = D. The fields are captured in the cycle the start request is accepted, so later changes on the field inputs have no effect on that load.
- R3: Each pass opens with an unlock preamble. Written as (DATA,CLK), its states are (0,0) then (1,0), then five repeats of (1,1),(1,0), then (0,0),(0,1).
- R4: The preamble is followed by a start bit made of the states (0,0) and (0,1).
- R5: The 24 data bits are sent LSB first. A 1 bit is sent as the four states (0,1),(0,0),(1,0),(1,1).
- R6: A 0 bit is sent as the four states (1,1),(1,0),(0,0),(0,1).
- R7: Each pass ends with the stop states (1,1),(1,0),(1,1).
- R8: The full series of preamble, start bit, data and stop is sent three times per accepted request, with no gap between passes. That is 115 states per pass and 345 in total.
- R9: Every wire state is held for exactly PHASE_CYCLES system clocks (default 4). The first state appears on the clock edge that accepts the start request.
- R10: busy rises on the accepting edge and stays high until the last state has been held. On the edge where busy falls, done is high for exactly one cycle and the clock-select output becomes 2. The wires then keep the final stop state (1,1).
- R11: A start request while busy is ignored: the wire sequence, its timing and the captured word are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load request, sampled each clock |
| idx_i | input | 4 | Index field |
| n_i | input | 7 | N divider field |
| p_i | input | 3 | P divider field |
| d_i | input | 7 | D divider field |
| ser_clk_o | output | 1 | Serial link clock wire |
| ser_data_o | output | 1 | Serial link data wire |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | One-cycle pulse at completion |
| sel_o | output | 4 | Clock-select value |

## Verification
The bench compares every clock cycle of each 345-state transfer against a wire trace it builds from the field values. It covers all-zero, all-one, alternating and arithmetic words. Any of these faults makes the trace diverge at a known state: a swapped or shifted field, MSB-first order, an inverted bit encoding, an off-by-one pulse count in the preamble, or a dropped third pass. A hold that is one cycle too short or too long shifts every later state, and that shows up as a mismatch. In one transfer a second request with different fields is injected mid-stream. A design that restarted or recaptured the word on that request would break the trace from that point on. The finishing edge is checked for select value 2, a done pulse of one cycle and the final wire state.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  localparam int IDX_W  = 4;
  localparam int N_W    = 7;
  localparam int P_W    = 3;
  localparam int D_W    = 7;
  localparam int WORD_W = 3 + IDX_W + N_W + P_W + D_W;
  localparam logic [2:0] REG_TARGET = 3'b010;

  typedef struct packed {
    logic d;
    logic c;
  } link_t;
endpackage

// File: rtl/serclk_word.sv
module serclk_word
  import serclk_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [P_W-1:0]    p_i,
  input  logic [D_W-1:0]    d_i,
  output logic [WORD_W-1:0] word_o
);
  // Target register select in the top bits, divider fields below.
  assign word_o = {REG_TARGET, idx_i, n_i, p_i, d_i};
endmodule

// File: rtl/serclk_timer.sv
module serclk_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/serclk_seq.sv
module serclk_seq
  import serclk_pkg::*;
#(
  parameter int UNLOCK_PULSES = 5,
  parameter int PASSES        = 3,
  parameter int SEL_W         = 4,
  parameter int SEL_LOAD      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tick_i,
  output logic              ser_clk_o,
  output logic              ser_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam int PRE_LEN  = 2 + 2 * UNLOCK_PULSES + 2;
  localparam int DATA_OFS = PRE_LEN + 2;
  localparam int STOP_OFS = DATA_OFS + 4 * WORD_W;
  localparam int STEPS    = STOP_OFS + 3;
  localparam int SW       = $clog2(STEPS);
  localparam int PW       = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);
  localparam logic [PW-1:0] LAST_PASS = PW'(PASSES - 1);

  logic [SW-1:0]     step_q;
  logic [PW-1:0]     pass_q;
  logic [WORD_W-1:0] word_q;
  link_t             link_q;

  // Wire state for a given position within one pass.
  function automatic link_t pattern(input int s, input logic [WORD_W-1:0] w);
    link_t r;
    int    j;
    logic  b;
    r = '{d: 1'b0, c: 1'b0};
    if (s == 0) begin
      r = '{d: 1'b0, c: 1'b0};
    end else if (s == 1) begin
      r = '{d: 1'b1, c: 1'b0};
    end else if (s < PRE_LEN - 2) begin
      j   = s - 2;
      r.d = 1'b1;
      r.c = (j % 2 == 0);
    end else if (s == PRE_LEN - 2) begin
      r = '{d: 1'b0, c: 1'b0};
    end else if (s == PRE_LEN - 1) begin
      r = '{d: 1'b0, c: 1'b1};
    end else if (s < DATA_OFS) begin
      r.d = 1'b0;
      r.c = (s == DATA_OFS - 1);
    end else if (s < STOP_OFS) begin
      j = s - DATA_OFS;
      b = w[j / 4];
      case (j % 4)
        0:       r = '{d: ~b, c: 1'b1};
        1:       r = '{d: ~b, c: 1'b0};
        2:       r = '{d: b,  c: 1'b0};
        default: r = '{d: b,  c: 1'b1};
      endcase
    end else begin
      r.d = 1'b1;
      r.c = (s != STOP_OFS + 1);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      pass_q <= '0;
      word_q <= '0;
      link_q <= '{d: 1'b0, c: 1'b0};
      busy_o <= 1'b0;
      done_o <= 1'b0;
      sel_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept_i) begin
        busy_o <= 1'b1;
        step_q <= '0;
        pass_q <= '0;
        word_q <= word_i;
        link_q <= pattern(0, word_i);
      end else if (busy_o && tick_i) begin
        if (step_q == LAST_STEP) begin
          if (pass_q == LAST_PASS) begin
            busy_o <= 1'b0;
            done_o <= 1'b1;
            sel_o  <= SEL_W'(SEL_LOAD);
          end else begin
            pass_q <= pass_q + 1'b1;
            step_q <= '0;
            link_q <= pattern(0, word_q);
          end
        end else begin
          step_q <= step_q + 1'b1;
          link_q <= pattern(int'(step_q) + 1, word_q);
        end
      end
    end
  end

  assign ser_clk_o  = link_q.c;
  assign ser_data_o = link_q.d;
endmodule

// File: rtl/serclk_prog.sv
module serclk_prog
  import serclk_pkg::*;
#(
  parameter int PHASE_CYCLES  = 4,
  parameter int UNLOCK_PULSES = 5,
  parameter int PASSES        = 3,
  parameter int SEL_W         = 4,
  parameter int SEL_LOAD      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [3:0]       idx_i,
  input  logic [6:0]       n_i,
  input  logic [2:0]       p_i,
  input  logic [6:0]       d_i,
  output logic             ser_clk_o,
  output logic             ser_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [SEL_W-1:0] sel_o
);
  logic              accept_w;
  logic              tick_w;
  logic [WORD_W-1:0] word_w;

  assign accept_w = start_i && !busy_o;

  serclk_word u_word (
    .idx_i  (idx_i),
    .n_i    (n_i),
    .p_i    (p_i),
    .d_i    (d_i),
    .word_o (word_w)
  );

  serclk_timer #(.CYCLES(PHASE_CYCLES)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart_i (accept_w),
    .run_i     (busy_o),
    .tick_o    (tick_w)
  );

  serclk_seq #(
    .UNLOCK_PULSES (UNLOCK_PULSES),
    .PASSES        (PASSES),
    .SEL_W         (SEL_W),
    .SEL_LOAD      (SEL_LOAD)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept_w),
    .word_i     (word_w),
    .tick_i     (tick_w),
    .ser_clk_o  (ser_clk_o),
    .ser_data_o (ser_data_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .sel_o      (sel_o)
  );
endmodule

// File: rtl/serclk_prog_chk.sv
module serclk_prog_chk #(
  parameter int SEL_W    = 4,
  parameter int SEL_LOAD = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             tick,
  input logic             ser_clk_o,
  input logic             ser_data_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [SEL_W-1:0] sel_o
);
  AST_RESET_VALUES: assert property (@(posedge clk)
    rst |=> (!ser_clk_o && !ser_data_o && !busy_o && !done_o && sel_o == '0)); // R1

  AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick) |=> $stable({ser_clk_o, ser_data_o})); // R9

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && sel_o == SEL_W'(SEL_LOAD))); // R10

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick) |=> busy_o); // R11
endmodule

bind serclk_prog serclk_prog_chk #(.SEL_W(SEL_W), .SEL_LOAD(SEL_LOAD)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .tick       (tick_w),
  .ser_clk_o  (ser_clk_o),
  .ser_data_o (ser_data_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sel_o      (sel_o)
);

// File: tb/serclk_prog_tb_top.sv
module serclk_prog_tb_top;
  localparam int P      = 4;
  localparam int NSTEP  = 345;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [3:0] idx_i = '0;
  logic [6:0] n_i = '0;
  logic [2:0] p_i = '0;
  logic [6:0] d_i = '0;
  logic       ser_clk_o, ser_data_o, busy_o, done_o;
  logic [3:0] sel_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic  exp_d [NSTEP];
  logic  exp_c [NSTEP];
  string exp_tag [NSTEP];
  int    fill;
  string cur_tag;

  always #4 clk = ~clk;

  serclk_prog #(.PHASE_CYCLES(P)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .idx_i(idx_i), .n_i(n_i), .p_i(p_i), .d_i(d_i),
    .ser_clk_o(ser_clk_o), .ser_data_o(ser_data_o),
    .busy_o(busy_o), .done_o(done_o), .sel_o(sel_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic d, input logic c);
    exp_d[fill]   = d;
    exp_c[fill]   = c;
    exp_tag[fill] = cur_tag;
    fill++;
  endtask

  task automatic build_trace(input int w);
    fill = 0;
    for (int ps = 0; ps < 3; ps++) begin
      cur_tag = (ps > 0) ? "R8 R3" : "R3";
      push(0, 0);
      cur_tag = "R3";
      push(1, 0);
      for (int k = 0; k < 5; k++) begin
        push(1, 1);
        push(1, 0);
      end
      push(0, 0);
      push(0, 1);
      cur_tag = "R4";
      push(0, 0);
      push(0, 1);
      for (int b = 0; b < 24; b++) begin
        if (((w >> b) & 1) == 1) begin
          cur_tag = "R2 R5";
          push(0, 1); push(0, 0); push(1, 0); push(1, 1);
        end else begin
          cur_tag = "R2 R6";
          push(1, 1); push(1, 0); push(0, 0); push(0, 1);
        end
      end
      cur_tag = "R7";
      push(1, 1); push(1, 0); push(1, 1);
    end
  endtask

  task automatic run_load(input int ix, input int nv, input int pv, input int dv, input bit inject);
    int w;
    int mism;
    string t;
    w = 2 * 2097152 + ix * 131072 + nv * 1024 + pv * 128 + dv;
    build_trace(w);
    mism = 0;
    @(negedge clk);
    idx_i = 4'(ix); n_i = 7'(nv); p_i = 3'(pv); d_i = 7'(dv);
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    // Scramble fields: the captured word must not follow them (R2).
    idx_i = ~idx_i; n_i = ~n_i; p_i = ~p_i; d_i = ~d_i;
    for (int k = 0; k < NSTEP; k++) begin
      for (int ph = 0; ph < P; ph++) begin
        t = (ph == 0) ? exp_tag[k] : {exp_tag[k], " R9"};
        if (ser_data_o !== exp_d[k] || ser_clk_o !== exp_c[k]) mism++;
        chk(ser_data_o === exp_d[k] && ser_clk_o === exp_c[k], t,
            int'({ser_data_o, ser_clk_o}), int'({exp_d[k], exp_c[k]}));
        chk(busy_o === 1'b1 && done_o === 1'b0, "R10 busy", int'({busy_o, done_o}), 2);
        if (inject && k == 200 && ph == 0) begin
          start_i = 1'b1;
          idx_i = 4'(ix + 5); n_i = 7'(nv + 33); p_i = 3'(pv + 3); d_i = 7'(dv + 17);
        end
        if (inject && k == 200 && ph == 1) start_i = 1'b0;
        @(negedge clk);
      end
    end
    chk(done_o === 1'b1 && busy_o === 1'b0, "R10 finish", int'({busy_o, done_o}), 1);
    chk(sel_o === 4'd2, "R10 sel", int'(sel_o), 2);
    chk(ser_data_o === 1'b1 && ser_clk_o === 1'b1, "R10 final wires",
        int'({ser_data_o, ser_clk_o}), 3);
    @(negedge clk);
    chk(done_o === 1'b0, "R10 done pulse", int'(done_o), 0);
    chk(ser_data_o === 1'b1 && ser_clk_o === 1'b1 && sel_o === 4'd2, "R10 hold",
        int'({ser_data_o, ser_clk_o}), 3);
    if (inject) chk(mism == 0, "R11", mism, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(ser_clk_o === 1'b0 && ser_data_o === 1'b0, "R1 wires", int'({ser_data_o, ser_clk_o}), 0);
    chk(sel_o === 4'd0, "R1 sel", int'(sel_o), 0);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 flags", int'({busy_o, done_o}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && ser_clk_o === 1'b0, "R1 idle", int'({busy_o, ser_clk_o}), 0);

    run_load(0, 0, 0, 0, 0);
    run_load(15, 127, 7, 127, 0);
    run_load(5, 85, 5, 42, 1);
    for (int l = 0; l < 3; l++) begin
      run_load((l * 7 + 3) % 16, (l * 45 + 19) % 128, (l * 3 + 2) % 8, (l * 61 + 100) % 128, 0);
    end
    finish_run();
  end
endmodule